// File: doc/BRIEF.md
# Asymmetric Instruction Decode Steering

This block sits between an instruction queue and a row of decoder slots that are not equal in ability. Each cycle it looks at the oldest few pre-decoded instruction descriptors. Each descriptor carries a micro-op count, a flag marking an operation on a memory operand, and a byte length. The block hands the descriptors to the slots strictly in program order. Slot 0 is the general slot and takes any instruction. The other slots are simple: each takes only an instruction that becomes exactly one micro-op. Steering stops at the first instruction that a simple slot cannot take, and that instruction waits for the general slot in the next cycle.

The general slot can emit up to four micro-ops in one cycle. If an instruction needs more than that, the general slot emits the first four, and a sequencer emits the rest over the following cycles, at up to four per cycle. While the sequencer is running, every slot stays idle and nothing is taken from the queue. The block reports three things each cycle: how many entries the queue must pop, the total number of micro-ops emitted, and a running program-order tag for every occupied slot. It also caps the instruction bytes decoded in one cycle at the fetch width.

Top module: `asym_decode_steer`

## Requirements
- R1: While `rst` is low and the sequencer is idle, a valid window entry 0 is always placed in slot 0, whatever its micro-op count or memory flag.
- R2: A simple slot takes only an entry whose micro-op count is exactly 1 and whose memory flag (`in_mem`) is 0. Any other entry is never placed in slot 1 or slot 2.
- R3: Placement is in order. Slot k holds window entry k, and only when slots 0..k-1 are all occupied. Steering stops at the first entry that is not simple, and also when entry 0 is a long instruction.
- R4: The sum of the byte lengths of the entries placed in one cycle never exceeds 16. Slot 0 is exempt from this limit. A simple entry that would push the sum past 16 is not placed, and neither is any entry after it.
- R5: An instruction in slot 0 with a count of 4 or less emits its count. Each occupied simple slot emits one micro-op. `uops_out` is the sum for the cycle, at most 6.
- R6: An instruction in slot 0 with a count N greater than 4 emits 4 micro-ops in that cycle. The sequencer then asserts `seq_busy` from the next cycle onward and emits min(4, remaining) per cycle until all N are out. `seq_busy` drops in the cycle after the last chunk.
- R7: While `seq_busy` is high, no slot is valid and `consumed` is 0.
- R8: `consumed` equals the number of occupied slots in the same cycle.
- R9: The tag of an occupied slot k is (number of instructions consumed since reset + k) mod 256. The tag field of an unoccupied slot is 0.
- R10: A synchronous reset clears the sequencer and the tag count. While `rst` is high, all slots are idle, `consumed` and `uops_out` are 0, and `seq_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 3 | Valid flag of each window entry; entry 0 is the oldest; the flags are contiguous from entry 0 |
| in_uops | input | 15 | Micro-op count of each entry, 5 bits per entry, entry k at bits [5k+4:5k] |
| in_mem | input | 3 | Memory-operand flag of each entry |
| in_len | input | 12 | Byte length (1..15) of each entry, 4 bits per entry |
| slot_valid | output | 3 | Occupancy of each slot; bit 0 is the general slot |
| slot_tag | output | 24 | Program-order tag of each slot, 8 bits per slot |
| uops_out | output | 3 | Micro-ops emitted this cycle, from the slots and the sequencer together |
| consumed | output | 2 | Number of queue entries to pop at the coming clock edge |
| seq_busy | output | 1 | Sequencer is emitting the tail of a long instruction |

## Verification
Slot occupancy, tags, `uops_out` and `consumed` depend combinationally on the window and on the registered state. They are therefore due in the same cycle the window is presented. The bench drives the window on the falling edge and compares one time unit later, before the next rising edge. The sequencer's remaining count and the tag base are registered, so a long instruction accepted in cycle t first shows `seq_busy` in cycle t+1. The bench's reference model advances its own remaining count, tag base and queue only at the rising edge, which makes its expectations land in exactly those cycles.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int STEER_SLOTS       = 3;
  localparam int STEER_GEN_MAX     = 4;
  localparam int STEER_FETCH_BYTES = 16;

  // an entry a simple slot may take
  function automatic bit simple_ok(input int n_uops, input bit mem);
    return (n_uops == 1) && !mem;
  endfunction

  // micro-ops the sequencer releases in one cycle
  function automatic int seq_chunk(input int remaining, input int cap);
    return (remaining > cap) ? cap : remaining;
  endfunction

endpackage

// File: rtl/steer_pick.sv
module steer_pick
  import steer_pkg::*;
#(
  parameter int SLOTS       = STEER_SLOTS,
  parameter int CNTW        = 5,
  parameter int LENW        = 4,
  parameter int GEN_MAX     = STEER_GEN_MAX,
  parameter int FETCH_BYTES = STEER_FETCH_BYTES,
  parameter int CW          = $clog2(SLOTS + 1),
  parameter int GW          = $clog2(GEN_MAX + 1)
) (
  input  logic                    en,
  input  logic [SLOTS-1:0]        in_valid,
  input  logic [SLOTS*CNTW-1:0]   in_uops,
  input  logic [SLOTS-1:0]        in_mem,
  input  logic [SLOTS*LENW-1:0]   in_len,
  output logic [SLOTS-1:0]        take,
  output logic                    head_long,
  output logic [GW-1:0]           gen_uops,
  output logic [CW-1:0]           n_take
);

  localparam int ACCW = LENW + $clog2(SLOTS) + 1;

  always_comb begin
    logic [ACCW-1:0] bytes_run;
    logic            chain;
    take      = '0;
    head_long = int'(in_uops[CNTW-1:0]) > GEN_MAX;
    bytes_run = ACCW'(in_len[LENW-1:0]);
    chain     = en && in_valid[0];
    take[0]   = chain;
    chain     = chain && !head_long;
    for (int k = 1; k < SLOTS; k++) begin
      bytes_run = bytes_run + ACCW'(in_len[k*LENW +: LENW]);
      chain = chain && in_valid[k]
           && simple_ok(int'(in_uops[k*CNTW +: CNTW]), in_mem[k])
           && (int'(bytes_run) <= FETCH_BYTES);
      take[k] = chain;
    end
  end

  always_comb begin
    n_take = '0;
    for (int k = 0; k < SLOTS; k++) n_take = n_take + CW'(take[k]);
  end

  always_comb begin
    if (!take[0])      gen_uops = '0;
    else if (head_long) gen_uops = GW'(GEN_MAX);
    else               gen_uops = in_uops[GW-1:0];
  end

endmodule

// File: rtl/steer_seq.sv
module steer_seq
  import steer_pkg::*;
#(
  parameter int CNTW    = 5,
  parameter int GEN_MAX = STEER_GEN_MAX,
  parameter int GW      = $clog2(GEN_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CNTW-1:0] load_cnt,
  output logic            busy,
  output logic [GW-1:0]   emit
);

  logic [CNTW-1:0] remaining;

  assign busy = !rst && (remaining != '0);
  assign emit = busy ? GW'(seq_chunk(int'(remaining), GEN_MAX)) : '0;

  always_ff @(posedge clk) begin
    if (rst)       remaining <= '0;
    else if (busy) remaining <= remaining - CNTW'(emit);
    else if (load) remaining <= load_cnt - CNTW'(GEN_MAX);
  end

endmodule

// File: rtl/steer_tag.sv
module steer_tag #(
  parameter int SLOTS = 3,
  parameter int IDW   = 8,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SLOTS-1:0]     take,
  input  logic [CW-1:0]        n_take,
  output logic [SLOTS*IDW-1:0] tags
);

  logic [IDW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) base <= '0;
    else     base <= base + IDW'(n_take);
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_tag
    assign tags[k*IDW +: IDW] = take[k] ? base + IDW'(k) : '0;
  end

endmodule

// File: rtl/asym_decode_steer.sv
module asym_decode_steer
  import steer_pkg::*;
#(
  parameter int SLOTS       = STEER_SLOTS,
  parameter int CNTW        = 5,
  parameter int LENW        = 4,
  parameter int IDW         = 8,
  parameter int GEN_MAX     = STEER_GEN_MAX,
  parameter int FETCH_BYTES = STEER_FETCH_BYTES,
  localparam int CW         = $clog2(SLOTS + 1),
  localparam int GW         = $clog2(GEN_MAX + 1),
  localparam int OUTW       = $clog2(GEN_MAX + SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SLOTS-1:0]      in_valid,
  input  logic [SLOTS*CNTW-1:0] in_uops,
  input  logic [SLOTS-1:0]      in_mem,
  input  logic [SLOTS*LENW-1:0] in_len,
  output logic [SLOTS-1:0]      slot_valid,
  output logic [SLOTS*IDW-1:0]  slot_tag,
  output logic [OUTW-1:0]       uops_out,
  output logic [CW-1:0]         consumed,
  output logic                  seq_busy
);

  // named internal events, visible to the checker
  logic [SLOTS-1:0] take;
  logic             head_long;
  logic [GW-1:0]    gen_uops;
  logic [GW-1:0]    seq_emit;
  logic [CW-1:0]    n_take;
  logic             pick_en;
  logic             seq_load;

  assign pick_en  = !rst && !seq_busy;
  assign seq_load = take[0] && head_long;

  steer_pick #(
    .SLOTS(SLOTS), .CNTW(CNTW), .LENW(LENW),
    .GEN_MAX(GEN_MAX), .FETCH_BYTES(FETCH_BYTES), .CW(CW), .GW(GW)
  ) u_pick (
    .en(pick_en), .in_valid(in_valid), .in_uops(in_uops), .in_mem(in_mem),
    .in_len(in_len), .take(take), .head_long(head_long),
    .gen_uops(gen_uops), .n_take(n_take)
  );

  steer_seq #(.CNTW(CNTW), .GEN_MAX(GEN_MAX), .GW(GW)) u_seq (
    .clk(clk), .rst(rst), .load(seq_load), .load_cnt(in_uops[CNTW-1:0]),
    .busy(seq_busy), .emit(seq_emit)
  );

  steer_tag #(.SLOTS(SLOTS), .IDW(IDW), .CW(CW)) u_tag (
    .clk(clk), .rst(rst), .take(take), .n_take(n_take), .tags(slot_tag)
  );

  assign slot_valid = take;
  assign consumed   = n_take;
  // simple slots add one micro-op each: every taken slot beyond slot 0
  assign uops_out   = OUTW'(gen_uops) + OUTW'(seq_emit)
                    + (take[0] ? OUTW'(n_take) - OUTW'(1) : '0);

endmodule

// File: rtl/asym_decode_steer_chk.sv
module asym_decode_steer_chk #(
  parameter int SLOTS   = 3,
  parameter int GEN_MAX = 4,
  parameter int CW      = 2,
  parameter int OUTW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [SLOTS-1:0] in_valid,
  input logic [SLOTS-1:0] slot_valid,
  input logic [OUTW-1:0]  uops_out,
  input logic [CW-1:0]    consumed,
  input logic             seq_busy
);

  assert_head_placed_R1: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && in_valid[0]) |-> slot_valid[0]);

  assert_in_order_R3: assert property (@(posedge clk) disable iff (rst)
    (slot_valid != '0) |-> slot_valid[0]);

  assert_uop_bound_R5: assert property (@(posedge clk) disable iff (rst)
    int'(uops_out) <= GEN_MAX + SLOTS - 1);

  assert_seq_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_busy) |-> ($past(slot_valid[0]) && $past(consumed) == CW'(1)));

  assert_seq_tail_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && int'(uops_out) < GEN_MAX) |=> !seq_busy);

  assert_idle_in_seq_R7: assert property (@(posedge clk) disable iff (rst)
    seq_busy |-> (slot_valid == '0 && consumed == '0));

  always @(negedge clk) begin
    if (rst) begin
      assert_reset_quiet_R10: assert (slot_valid == '0 && !seq_busy && uops_out == '0);
    end
  end

endmodule

bind asym_decode_steer asym_decode_steer_chk #(
  .SLOTS(SLOTS), .GEN_MAX(GEN_MAX), .CW(CW), .OUTW(OUTW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .slot_valid(slot_valid),
  .uops_out(uops_out), .consumed(consumed), .seq_busy(seq_busy)
);

// File: tb/tb_asym_decode_steer.sv
`timescale 1ns/1ps
module tb_asym_decode_steer;

  localparam int NS = 3, CNTW = 5, LENW = 4, IDW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS-1:0]   in_valid = '0;
  logic [NS*CNTW-1:0] in_uops = '0;
  logic [NS-1:0]   in_mem = '0;
  logic [NS*LENW-1:0] in_len = '0;
  logic [NS-1:0]   slot_valid;
  logic [NS*IDW-1:0] slot_tag;
  logic [2:0]      uops_out;
  logic [1:0]      consumed;
  logic            seq_busy;

  always #5 clk = ~clk;

  asym_decode_steer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
    .in_mem(in_mem), .in_len(in_len), .slot_valid(slot_valid),
    .slot_tag(slot_tag), .uops_out(uops_out), .consumed(consumed),
    .seq_busy(seq_busy)
  );

  typedef struct { int uops; bit mem; int len; } ins_t;
  ins_t q[$];

  int total = 0, bad = 0;
  int m_rem = 0, m_base = 0;
  int last_cons, last_valid, last_busy, last_uops;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_simple(input ins_t i);
    return i.uops == 1 && !i.mem;
  endfunction

  task automatic push(input int u, input bit m, input int l);
    ins_t i;
    i.uops = u; i.mem = m; i.len = l;
    q.push_back(i);
  endtask

  // one clock: drive window, compare with model, advance model at edge
  task automatic step(input bit r);
    int e_valid, e_uops, e_cons, e_busy, new_rem, bytes;
    int e_tag[NS];
    @(negedge clk);
    rst = r;
    for (int k = 0; k < NS; k++) begin
      in_valid[k] = (k < q.size());
      in_uops[k*CNTW +: CNTW] = (k < q.size()) ? CNTW'(q[k].uops) : '0;
      in_mem[k]  = (k < q.size()) ? q[k].mem : 1'b0;
      in_len[k*LENW +: LENW] = (k < q.size()) ? LENW'(q[k].len) : '0;
    end
    #1;
    e_valid = 0; e_uops = 0; e_cons = 0; e_busy = 0; new_rem = m_rem;
    for (int k = 0; k < NS; k++) e_tag[k] = 0;
    if (!r) begin
      if (m_rem > 0) begin
        e_busy = 1;
        e_uops = (m_rem > 4) ? 4 : m_rem;
        new_rem = m_rem - e_uops;
      end else if (q.size() > 0) begin
        e_valid = 1; e_cons = 1; e_tag[0] = m_base % 256;
        bytes = q[0].len;
        if (q[0].uops > 4) begin
          e_uops = 4; new_rem = q[0].uops - 4;
        end else begin
          e_uops = q[0].uops;
          for (int k = 1; k < NS; k++) begin
            if (k >= q.size() || !is_simple(q[k]) || bytes + q[k].len > 16) break;
            bytes += q[k].len;
            e_valid |= (1 << k); e_cons++; e_uops++;
            e_tag[k] = (m_base + k) % 256;
          end
        end
      end
    end
    chk("R1 R2 R3 R4 R7 R10 slot_valid", int'(slot_valid), e_valid);
    for (int k = 0; k < NS; k++) chk("R9 slot_tag", int'(slot_tag[k*IDW +: IDW]), e_tag[k]);
    chk("R5 R6 uops_out", int'(uops_out), e_uops);
    chk("R8 consumed", int'(consumed), e_cons);
    chk("R6 R10 seq_busy", int'(seq_busy), e_busy);
    last_cons = int'(consumed); last_valid = int'(slot_valid);
    last_busy = int'(seq_busy); last_uops = int'(uops_out);
    @(posedge clk);
    if (r) begin
      m_rem = 0; m_base = 0;
    end else begin
      for (int c = 0; c < e_cons; c++) void'(q.pop_front());
      m_rem = new_rem;
      m_base = (m_base + e_cons) % 256;
    end
  endtask

  task automatic drain();
    for (int n = 0; n < 2000 && (q.size() > 0 || m_rem > 0); n++) step(1'b0);
  endtask

  initial begin
    step(1'b1);
    step(1'b1);
    chk("R10 reset idle", last_valid, 0);
    chk("R10 reset busy", last_busy, 0);

    // three simple one-byte entries, all taken together
    repeat (6) push(1, 1'b0, 1);
    step(1'b0);
    chk("R8 three taken", last_cons, 3);
    drain();

    // complex head (3 uops) followed by simples
    push(3, 1'b0, 4); push(1, 1'b0, 2); push(1, 1'b0, 2);
    step(1'b0);
    chk("R1 complex head placed", last_valid & 1, 1);
    chk("R5 complex head emission", last_uops, 5);
    drain();

    // simple head, then a memory-flagged single-uop entry blocks
    push(1, 1'b0, 2); push(1, 1'b1, 3); push(1, 1'b0, 2);
    step(1'b0);
    chk("R2 mem entry kept from simple slot", last_cons, 1);
    step(1'b0);
    chk("R3 mem entry moves to slot 0", last_cons, 2);
    drain();

    // simple then complex: stop after slot 0
    push(1, 1'b0, 1); push(2, 1'b0, 1); push(1, 1'b0, 1);
    step(1'b0);
    chk("R3 stop at complex", last_cons, 1);
    drain();

    // byte budget: 8+8+1 exceeds, 6+5+5 fits exactly
    push(1, 1'b0, 8); push(1, 1'b0, 8); push(1, 1'b0, 1);
    step(1'b0);
    chk("R4 budget exceeded", last_cons, 2);
    drain();
    push(1, 1'b0, 6); push(1, 1'b0, 5); push(1, 1'b0, 5);
    step(1'b0);
    chk("R4 budget exact", last_cons, 3);
    drain();
    push(15, 1'b0, 15); push(1, 1'b0, 1);
    drain();

    // long instructions: 9 (4,4,1), 8 (4,4), 5 (4,1)
    push(9, 1'b0, 3); push(1, 1'b0, 1); push(1, 1'b0, 1);
    step(1'b0);
    chk("R6 long accept", last_uops, 4);
    chk("R6 long alone", last_cons, 1);
    step(1'b0);
    chk("R7 idle while sequencing", last_valid, 0);
    chk("R7 nothing consumed", last_cons, 0);
    drain();
    push(8, 1'b1, 5); push(5, 1'b0, 2); push(1, 1'b0, 1);
    drain();

    // reset while the sequencer is busy
    push(20, 1'b0, 4); push(1, 1'b0, 1);
    step(1'b0); step(1'b0);
    step(1'b1);
    chk("R10 reset quiets sequencer", last_busy, 0);
    step(1'b0);
    chk("R10 sequencer cleared", last_busy, 0);
    chk("R9 tag restarts", int'(slot_tag[7:0]), 0);
    drain();

    // random mix
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 10) < 6) push(1, 1'b0, 1 + ($urandom % 15));
      else push(1 + ($urandom % 14), 1'($urandom % 2), 1 + ($urandom % 15));
    end
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule